// File: doc/BRIEF.md
# Bus-Loaded Segment Register Bank with Strap Subaddressing

This block is a receive-only I2C slave that fills the storage of a segmented display driver. It oversamples SCL and SDA on the system clock. It answers one fixed 7-bit write address. The first byte after that address always goes into a control register. This byte carries a drive-mode flag, a bank flag and a 6-bit pointer. Every chip that sees its address takes a copy of this byte, so all chips on a shared bus keep the same mode, bank and pointer.

The following bytes land in one of eight segment registers. The low three pointer bits pick the register. The high pointer bits name the chip that owns the byte: they are compared with three strap pins. The pointer advances after every byte, on every chip, whether or not that chip owned the byte. A run of bytes can therefore flow from one chip into the next when the straps are numbered in sequence. The step is two in direct mode, which keeps a stream inside one bank, and one in duplex mode.

Top module: `i2c_seg_loader`

## Requirements
- R1: A byte after a start or repeated start is acknowledged only if it equals the 7-bit address (default 0111010) followed by write bit 0. Any other address, including the same address with read bit 1, gets no acknowledge, and the bytes that follow in that transfer change no register.
- R2: After an accepted address, the next byte is always stored in the control register and always acknowledged, whatever the straps are. Bit 7 of this byte is MODE (0 direct, 1 duplex), bit 6 is BANK, and bits 5:0 are the pointer. `ctrl_o` shows the whole register, and `mode_o` and `bank_o` show bits 7 and 6.
- R3: In direct mode, a later byte is acknowledged and written to segment register pointer[2:0] when pointer[5:3] equals `strap_i[2:0]`. Register k appears on `seg_o[8k+7:8k]`.
- R4: In duplex mode, only pointer[4:3] is compared with `strap_i[1:0]`. Pointer bit 5 and `strap_i[2]` are ignored.
- R5: On a strap mismatch, a data byte gets no acknowledge and writes no segment register, but the pointer still advances.
- R6: After each data byte, the pointer grows by 2 in direct mode and by 1 in duplex mode, modulo 64.
- R7: A stop right after the control byte's acknowledge leaves all segment registers unchanged. A stop always ends loading.
- R8: A repeated start in the middle of a transfer begins a new address phase, followed by a new control byte.
- R9: Reset clears the control register and all eight segment registers, releases SDA and returns the receiver to idle.
- R10: `sda_oe` is raised only while SCL is low at the start of an acknowledge slot. It is never high during the eight data bit slots of a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Hardware subaddress pins |
| sda_oe | output | 1 | Pull-down enable for SDA (open drain) |
| ctrl_o | output | 8 | Control register: mode, bank, pointer |
| mode_o | output | 1 | 1 = duplex, 0 = direct |
| bank_o | output | 1 | Bank select flag |
| seg_o | output | 64 | Eight segment registers, register k in bits 8k+7:8k |

## Verification
The bench builds the block with the default address 0111010 and a three-stage synchronizer. Against the bench's quarter-bit time of five clocks, this shows that the input latency fits inside a bus phase. With these values, a table of transfers reaches the following cases:
- a two-byte stream whose pointer leaves the strap window halfway;
- a duplex match where strap bit 2 disagrees with pointer bit 5;
- the pointer wrapping from 111110 and from 111111;
- a chip whose straps never match.

Directed transfers cover a wrong address, a read address, a stop right after the control byte, a repeated start, and reset in the middle of a frame.

// File: rtl/i2c_seg_loader.sv
module i2c_seg_loader #(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [2:0]  strap_i,
  output logic        sda_oe,
  output logic [7:0]  ctrl_o,
  output logic        mode_o,
  output logic        bank_o,
  output logic [63:0] seg_o
);
  localparam int NREG = 8;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_CTRL, ST_DATA, ST_SKIP} st_t;

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic       scl_s, sda_s, scl_p, sda_p;
  st_t        st;
  logic [3:0] bit_cnt;
  logic       in_ack;
  logic [7:0] sh;
  logic [7:0] ctrl_q;
  logic [7:0] seg_q [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire active   = (st == ST_ADDR) || (st == ST_CTRL) || (st == ST_DATA);
  wire byte_end = active && scl_fall && !in_ack && (bit_cnt == 4'd8);

  wire       dev_match = ctrl_q[7] ? (ctrl_q[4:3] == strap_i[1:0]) : (ctrl_q[5:3] == strap_i);
  wire [5:0] step      = ctrl_q[7] ? 6'd1 : 6'd2;
  wire       data_evt  = byte_end && (st == ST_DATA);
  wire       ctrl_evt  = byte_end && (st == ST_CTRL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      sh      <= '0;
      sda_oe  <= 1'b0;
      ctrl_q  <= '0;
      for (int i = 0; i < NREG; i++) seg_q[i] <= '0;
    end else if (start_c) begin
      st      <= ST_ADDR;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_c) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (active) begin
      if (scl_rise && !in_ack) begin
        sh      <= {sh[6:0], sda_s};
        bit_cnt <= 4'(bit_cnt + 4'd1);
      end
      if (byte_end) begin
        in_ack <= 1'b1;
        case (st)
          ST_ADDR: sda_oe <= (sh == {DEV_ADDR, 1'b0});
          ST_CTRL: begin
            sda_oe <= 1'b1;
            ctrl_q <= sh;
          end
          ST_DATA: begin
            sda_oe <= dev_match;
            if (dev_match) seg_q[ctrl_q[2:0]] <= sh;
            ctrl_q[5:0] <= ctrl_q[5:0] + step;
          end
          default: ;
        endcase
      end else if (scl_fall && in_ack) begin
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
        bit_cnt <= '0;
        case (st)
          ST_ADDR: st <= sda_oe ? ST_CTRL : ST_SKIP;
          ST_CTRL: st <= ST_DATA;
          default: ;
        endcase
      end
    end

  assign ctrl_o = ctrl_q;
  assign mode_o = ctrl_q[7];
  assign bank_o = ctrl_q[6];

  for (genvar g = 0; g < NREG; g++) begin : g_seg
    assign seg_o[8*g +: 8] = seg_q[g];
  end
endmodule

module seg_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        sda_oe,
  input logic [7:0]  ctrl_o,
  input logic [63:0] seg_o,
  input logic        dev_match,
  input logic        data_evt,
  input logic        ctrl_evt
);
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (ctrl_o == 8'h00 && seg_o == 64'h0 && !sda_oe));

  // R10
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R5
  nomatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_match |=> $stable(seg_o));

  // R6
  vec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_evt |=> ctrl_o[5:0] == 6'($past(ctrl_o[5:0]) + ($past(ctrl_o[7]) ? 6'd1 : 6'd2)));

  // R3
  match_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_evt |=> (sda_oe == $past(dev_match)));

  // R2
  ctrl_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_evt |=> sda_oe);
endmodule

bind i2c_seg_loader seg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .ctrl_o(ctrl_o), .seg_o(seg_o), .dev_match(dev_match),
  .data_evt(data_evt), .ctrl_evt(ctrl_evt)
);

// File: tb/tb_i2c_seg_loader.sv
module tb_i2c_seg_loader;
  localparam int Q = 5;
  localparam logic [7:0] WADDR = {7'h3A, 1'b0};

  // {strap, ctrl, d0, d1, ack0, ack1, idx0, idx1, final ctrl}
  localparam logic [42:0] TBL [7] = '{
    {3'b000, 8'h00, 8'h11, 8'h22, 1'b1, 1'b1, 3'd0, 3'd2, 8'h04},
    {3'b000, 8'h85, 8'h33, 8'h44, 1'b1, 1'b1, 3'd5, 3'd6, 8'h87},
    {3'b001, 8'h4E, 8'h55, 8'h66, 1'b1, 1'b0, 3'd6, 3'd0, 8'h52},
    {3'b101, 8'h8F, 8'h77, 8'h88, 1'b1, 1'b0, 3'd7, 3'd0, 8'h91},
    {3'b111, 8'h3E, 8'h99, 8'hAA, 1'b1, 1'b0, 3'd6, 3'd0, 8'h02},
    {3'b011, 8'hBF, 8'hBB, 8'hCC, 1'b1, 1'b0, 3'd7, 3'd0, 8'h81},
    {3'b100, 8'h00, 8'hDD, 8'hEE, 1'b0, 1'b0, 3'd0, 3'd0, 8'h04}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic [2:0] strap = 3'b000;
  logic sda_oe, mode_o, bank_o;
  logic [7:0] ctrl_o;
  logic [63:0] seg_o;
  wire sda_w = sda_drv & ~sda_oe;

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] shadow = '0;
  logic ack;

  always #5 clk = ~clk;

  i2c_seg_loader #(.DEV_ADDR(7'h3A), .SYNC_STAGES(3)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_w), .strap_i(strap),
    .sda_oe(sda_oe), .ctrl_o(ctrl_o), .mode_o(mode_o), .bank_o(bank_o), .seg_o(seg_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; w(Q); scl = 1'b1; w(Q); sda_drv = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; w(Q); scl = 1'b1; w(Q); sda_drv = 1'b1; w(Q);
  endtask

  task automatic send(input logic [7:0] b, output logic a);
    logic oe_seen;
    oe_seen = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; w(Q); scl = 1'b1; w(Q);
      oe_seen |= sda_oe;
      w(Q); scl = 1'b0; w(Q);
    end
    sda_drv = 1'b1; w(Q); scl = 1'b1; w(Q);
    a = ~sda_w;
    w(Q); scl = 1'b0; w(Q);
    chk("R10 sda_oe during data bits", {63'd0, oe_seen}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [42:0] e;
    w(5); rst_n = 1'b1; w(5);
    chk("R9 reset ctrl", {56'd0, ctrl_o}, 64'd0);
    chk("R9 reset seg", seg_o, 64'd0);
    chk("R9 reset sda_oe", {63'd0, sda_oe}, 64'd0);

    for (int k = 0; k < 7; k++) begin
      e = TBL[k];
      strap = e[42:40];
      bus_start();
      send(WADDR, ack);    chk("R1 address ack", {63'd0, ack}, 64'd1);
      send(e[39:32], ack); chk("R2 control ack", {63'd0, ack}, 64'd1);
      send(e[31:24], ack); chk("R3/R4/R5 first data ack", {63'd0, ack}, {63'd0, e[15]});
      if (e[15]) shadow[8*e[13:11] +: 8] = e[31:24];
      send(e[23:16], ack); chk("R3/R4/R5 second data ack", {63'd0, ack}, {63'd0, e[14]});
      if (e[14]) shadow[8*e[10:8] +: 8] = e[23:16];
      bus_stop();
      chk("R6 pointer after stream", {56'd0, ctrl_o}, {56'd0, e[7:0]});
      chk("R2 mode and bank flags", {62'd0, mode_o, bank_o}, {62'd0, e[7:6]});
      chk("R3/R4/R5 segment contents", seg_o, shadow);
    end

    // R1: foreign address and read address
    strap = 3'b000;
    bus_start();
    send({7'h3B, 1'b0}, ack); chk("R1 foreign address nack", {63'd0, ack}, 64'd0);
    send(8'h55, ack);         chk("R1 byte after foreign address nack", {63'd0, ack}, 64'd0);
    bus_stop();
    chk("R1 ctrl unchanged after foreign address", {56'd0, ctrl_o}, 64'h04);
    bus_start();
    send({7'h3A, 1'b1}, ack); chk("R1 read address nack", {63'd0, ack}, 64'd0);
    send(8'h66, ack);
    bus_stop();
    chk("R1 ctrl unchanged after read address", {56'd0, ctrl_o}, 64'h04);
    chk("R1 seg unchanged", seg_o, shadow);

    // R7: stop right after control byte
    bus_start();
    send(WADDR, ack);
    send(8'hC0, ack); chk("R7 control ack", {63'd0, ack}, 64'd1);
    bus_stop();
    chk("R7 ctrl loaded", {56'd0, ctrl_o}, 64'hC0);
    chk("R7 segments unchanged", seg_o, shadow);

    // R8: repeated start
    bus_start();
    send(WADDR, ack);
    send(8'h00, ack);
    send(8'hA1, ack); chk("R8 data before restart ack", {63'd0, ack}, 64'd1);
    shadow[7:0] = 8'hA1;
    bus_start();
    send(WADDR, ack); chk("R8 address after restart ack", {63'd0, ack}, 64'd1);
    send(8'h82, ack); chk("R8 new control byte ack", {63'd0, ack}, 64'd1);
    send(8'hB2, ack); chk("R8 data after restart ack", {63'd0, ack}, 64'd1);
    shadow[23:16] = 8'hB2;
    bus_stop();
    chk("R8 ctrl after restart", {56'd0, ctrl_o}, 64'h83);
    chk("R8 segment contents", seg_o, shadow);

    // R9: reset during a transfer
    bus_start();
    send(WADDR, ack);
    send(8'h8A, ack);
    rst_n = 1'b0; scl = 1'b1; sda_drv = 1'b1; w(3);
    rst_n = 1'b1; w(5);
    chk("R9 ctrl cleared", {56'd0, ctrl_o}, 64'd0);
    chk("R9 seg cleared", seg_o, 64'd0);
    chk("R9 sda released", {63'd0, sda_oe}, 64'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule